// File: doc/BRIEF.md
# Shadow Memory Bus Mode Controller

This block sits between a 16-bit processor with a 20-bit address and the memories and peripherals around it. Each bus cycle, from the processor or from a DMA engine, goes to exactly one of three targets: the boot ROM, the SDRAM, or the peripheral chip-select bus. The target depends on a mode word that software keeps in a bus control register. The processor reaches that register through an I/O access to port EAh.

Software uses the block in three steps. At boot, code runs from ROM. Software then selects the copy mode and programs the DMA engine with the same source and destination address. In that mode, DMA reads come from ROM and DMA writes land in SDRAM at the same address, while the processor keeps fetching its code from ROM. After the copy, software selects the shadow mode, and instruction fetches in the ROM window are then served from SDRAM.

The block also forms the address of I/O cycles. It chooses whether peripheral cycles use the shared multiplexed bus or the separate address/data bus, and it reports the width of each code fetch.

Top module: `shadow_bus_ctrl`

## Requirements
- R1: After reset the control word reads 0000h, and an instruction fetch in the ROM window (address bits [19:16] = Fh) goes to the ROM.
- R2: An I/O access to port EAh reads or writes the control word as a full 16-bit word. The access is acknowledged in the same cycle and selects no external target. Bit 15 is the bus mode, bit 2 is the wide-fetch bit and bits [1:0] are the shadow mode. All other bits read as zero, so writing FFFFh reads back 8007h. Mode 11 reads back as written.
- R3: In mode 00, and in mode 11, which behaves like 00: accesses to the ROM window go to the ROM, and memory accesses outside the ROM and peripheral windows go to the SDRAM.
- R4: In mode 01 (copy), a DMA read of the ROM window goes to the ROM and a DMA write goes to the SDRAM at the same address. Processor fetches in the ROM window still go to the ROM.
- R5: In mode 10 (shadow), processor instruction fetches in the ROM window go to the SDRAM, and processor data reads of that window go to the ROM.
- R6: Memory accesses with address bits [19:16] = Ch go to the peripheral bus. When bit 15 is 0, the multiplexed-bus enable is high and the separate-bus enable is low. When bit 15 is 1, the separate-bus enable is high and the multiplexed-bus enable is low.
- R7: An I/O cycle to any port other than EAh goes to the peripheral bus. Its output address has bits [19:16] at zero and carries the 16-bit port number in bits [15:0].
- R8: During an instruction fetch, the wide-fetch output is high when the boot-width strap selects 16-bit boot or when bit 2 is set. Otherwise it is low.
- R9: A change to the control word that is written while an external cycle is still waiting for its acknowledge does not alter the routing of that cycle. The change applies from the next cycle.
- R10: When both masters request at a cycle start, the DMA engine wins. The owner of a cycle keeps the bus until the target acknowledges it, and only that owner sees the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot8 | input | 1 | Boot-width strap, 1 means 8-bit boot |
| cpu_req | input | 1 | Processor cycle request |
| cpu_fetch | input | 1 | Processor cycle is an instruction fetch |
| cpu_wr | input | 1 | Processor cycle writes |
| cpu_io | input | 1 | Processor cycle is an I/O cycle |
| cpu_addr | input | 20 | Processor address |
| cpu_wdata | input | 16 | Processor write data, used for the control word |
| cpu_rdata | output | 16 | Control word read data, zero unless the control word is read |
| cpu_ack | output | 1 | Processor cycle complete |
| dma_req | input | 1 | DMA cycle request |
| dma_wr | input | 1 | DMA cycle writes |
| dma_addr | input | 20 | DMA address |
| dma_ack | output | 1 | DMA cycle complete |
| tgt_ack | input | 1 | Acknowledge from the selected target |
| rom_sel | output | 1 | Boot ROM selected |
| sdram_sel | output | 1 | SDRAM selected |
| pcs_sel | output | 1 | Peripheral bus selected |
| out_addr | output | 20 | Address driven to the selected target |
| out_wr | output | 1 | Selected cycle writes |
| sad_en | output | 1 | Multiplexed peripheral bus in use |
| adbus_en | output | 1 | Separate address/data peripheral bus in use |
| fetch_wide | output | 1 | Current fetch is 16 bits wide |

## Verification
The selects, the output address, the bus enables, the fetch width, both acknowledges and the read data are combinational. The bench therefore drives each cycle at a falling edge and samples 2 ns later, in the same cycle. A control word write is captured at the next rising edge, and the routing it causes first shows up at the falling edge after that edge. Every check that depends on a new mode is made there. The held-cycle test keeps the acknowledge low over several edges and checks the selects at each falling edge. It then checks the first cycle after the acknowledge edge, which is where the new mode first applies.

// File: rtl/shadow_bus_pkg.sv
package shadow_bus_pkg;
  localparam int ADDR_W = 20;
  localparam int PORT_W = 16;
  localparam int SEG_W  = ADDR_W - PORT_W;

  typedef enum logic [1:0] {
    SHM_NORMAL = 2'b00,
    SHM_COPY   = 2'b01,
    SHM_SHADOW = 2'b10,
    SHM_RSVD   = 2'b11
  } shm_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE, TGT_ROM, TGT_SDRAM, TGT_PCS
  } tgt_e;

  typedef struct packed {
    logic              from_dma;
    logic              fetch;
    logic              wr;
    logic              io;
    logic [ADDR_W-1:0] addr;
  } bus_cyc_t;

  // Target choice for one cycle under a given shadow mode.
  function automatic tgt_e route_cycle(shm_mode_e m, bus_cyc_t c,
                                       logic [SEG_W-1:0] rom_seg,
                                       logic [SEG_W-1:0] pcs_seg);
    logic [SEG_W-1:0] seg;
    seg = c.addr[ADDR_W-1:PORT_W];
    if (c.io)                 return TGT_PCS;
    if (seg == pcs_seg)       return TGT_PCS;
    if (seg < rom_seg)        return TGT_SDRAM;
    case (m)
      SHM_COPY:   return (c.from_dma && c.wr) ? TGT_SDRAM : TGT_ROM;
      SHM_SHADOW: return (!c.from_dma && c.fetch) ? TGT_SDRAM : TGT_ROM;
      default:    return TGT_ROM;
    endcase
  endfunction

  // I/O cycles carry the port number and clear the segment bits.
  function automatic logic [ADDR_W-1:0] form_addr(bus_cyc_t c);
    return c.io ? {{SEG_W{1'b0}}, c.addr[PORT_W-1:0]} : c.addr;
  endfunction

  function automatic logic fetch_is_wide(logic boot8, logic wide_bit);
    return !boot8 || wide_bit;
  endfunction
endpackage

// File: rtl/sbc_ctrl_reg.sv
module sbc_ctrl_reg
  import shadow_bus_pkg::*;
#(
  parameter int            WORD_W    = 16,
  parameter logic [WORD_W-1:0] IMPL_MASK = 16'h8007,
  parameter int            BMOD_BIT  = 15,
  parameter int            WIDE_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output shm_mode_e         mode,
  output logic              bmod,
  output logic              wide
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (hit && wr) word_q <= wdata & IMPL_MASK;
  end

  assign word = word_q;
  assign mode = shm_mode_e'(word_q[1:0]);
  assign bmod = word_q[BMOD_BIT];
  assign wide = word_q[WIDE_BIT];

  // R2
  mode_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr) |=> (mode == shm_mode_e'($past(wdata[1:0])) && bmod == $past(wdata[BMOD_BIT])));
endmodule

// File: rtl/sbc_cycle_track.sv
module sbc_cycle_track
  import shadow_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dma_req,
  input  logic      cpu_ext,
  input  logic      tgt_ack,
  input  shm_mode_e reg_mode,
  input  logic      reg_bmod,
  input  logic      reg_wide,
  output logic      gnt_dma,
  output logic      ext_valid,
  output logic      cyc_open,
  output shm_mode_e eff_mode,
  output logic      eff_bmod,
  output logic      eff_wide
);
  logic      open_q, own_dma_q;
  shm_mode_e held_mode;
  logic      held_bmod, held_wide;

  assign cyc_open  = open_q;
  assign gnt_dma   = open_q ? own_dma_q : dma_req;
  assign ext_valid = gnt_dma ? dma_req : cpu_ext;
  assign eff_mode  = open_q ? held_mode : reg_mode;
  assign eff_bmod  = open_q ? held_bmod : reg_bmod;
  assign eff_wide  = open_q ? held_wide : reg_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      own_dma_q <= 1'b0;
      held_mode <= SHM_NORMAL;
      held_bmod <= 1'b0;
      held_wide <= 1'b0;
    end else begin
      open_q    <= ext_valid && !tgt_ack;
      own_dma_q <= gnt_dma;
      held_mode <= eff_mode;
      held_bmod <= eff_bmod;
      held_wide <= eff_wide;
    end
  end

  // R10
  owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !tgt_ack) |=> (gnt_dma == $past(gnt_dma)));
endmodule

// File: rtl/sbc_router.sv
module sbc_router
  import shadow_bus_pkg::*;
#(
  parameter logic [SEG_W-1:0] ROM_SEG = 4'hF,
  parameter logic [SEG_W-1:0] PCS_SEG = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  bus_cyc_t          cyc,
  input  shm_mode_e         mode,
  input  logic              bmod,
  input  logic              wide,
  input  logic              boot8,
  output logic              rom_sel,
  output logic              sdram_sel,
  output logic              pcs_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_wr,
  output logic              sad_en,
  output logic              adbus_en,
  output logic              fetch_wide
);
  tgt_e tgt;

  always_comb begin
    tgt        = valid ? route_cycle(mode, cyc, ROM_SEG, PCS_SEG) : TGT_NONE;
    rom_sel    = (tgt == TGT_ROM);
    sdram_sel  = (tgt == TGT_SDRAM);
    pcs_sel    = (tgt == TGT_PCS);
    out_addr   = valid ? form_addr(cyc) : '0;
    out_wr     = valid && cyc.wr;
    sad_en     = pcs_sel && !bmod;
    adbus_en   = pcs_sel && bmod;
    fetch_wide = valid && cyc.fetch && fetch_is_wide(boot8, wide);
  end

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, sdram_sel, pcs_sel}));
  // R6
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sad_en && adbus_en));
  // R7
  io_seg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cyc.io) |-> (out_addr[ADDR_W-1:PORT_W] == '0 && pcs_sel));
  // R5
  shadow_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == SHM_SHADOW && cyc.fetch && !cyc.from_dma &&
     cyc.addr[ADDR_W-1:PORT_W] >= ROM_SEG) |-> !rom_sel);
endmodule

// File: rtl/shadow_bus_ctrl.sv
module shadow_bus_ctrl
  import shadow_bus_pkg::*;
#(
  parameter logic [PORT_W-1:0] REG_PORT = 16'h00EA,
  parameter logic [SEG_W-1:0]  ROM_SEG  = 4'hF,
  parameter logic [SEG_W-1:0]  PCS_SEG  = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot8,
  input  logic              cpu_req,
  input  logic              cpu_fetch,
  input  logic              cpu_wr,
  input  logic              cpu_io,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [PORT_W-1:0] cpu_wdata,
  output logic [PORT_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  input  logic              dma_req,
  input  logic              dma_wr,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              dma_ack,
  input  logic              tgt_ack,
  output logic              rom_sel,
  output logic              sdram_sel,
  output logic              pcs_sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_wr,
  output logic              sad_en,
  output logic              adbus_en,
  output logic              fetch_wide
);
  logic              reg_hit, cpu_ext, gnt_dma, ext_valid, cyc_open;
  logic [PORT_W-1:0] reg_word;
  shm_mode_e         reg_mode, eff_mode;
  logic              reg_bmod, reg_wide, eff_bmod, eff_wide;
  bus_cyc_t          cyc;

  assign reg_hit = cpu_req && cpu_io && (cpu_addr[PORT_W-1:0] == REG_PORT);
  assign cpu_ext = cpu_req && !reg_hit;

  sbc_ctrl_reg #(.WORD_W(PORT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .hit(reg_hit), .wr(cpu_wr), .wdata(cpu_wdata),
    .word(reg_word), .mode(reg_mode), .bmod(reg_bmod), .wide(reg_wide)
  );

  sbc_cycle_track u_track (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cpu_ext(cpu_ext),
    .tgt_ack(tgt_ack), .reg_mode(reg_mode), .reg_bmod(reg_bmod),
    .reg_wide(reg_wide), .gnt_dma(gnt_dma), .ext_valid(ext_valid),
    .cyc_open(cyc_open), .eff_mode(eff_mode), .eff_bmod(eff_bmod),
    .eff_wide(eff_wide)
  );

  always_comb begin
    if (gnt_dma) cyc = '{from_dma: 1'b1, fetch: 1'b0, wr: dma_wr, io: 1'b0, addr: dma_addr};
    else         cyc = '{from_dma: 1'b0, fetch: cpu_fetch, wr: cpu_wr, io: cpu_io, addr: cpu_addr};
  end

  sbc_router #(.ROM_SEG(ROM_SEG), .PCS_SEG(PCS_SEG)) u_route (
    .clk(clk), .rst_n(rst_n), .valid(ext_valid), .cyc(cyc), .mode(eff_mode),
    .bmod(eff_bmod), .wide(eff_wide), .boot8(boot8), .rom_sel(rom_sel),
    .sdram_sel(sdram_sel), .pcs_sel(pcs_sel), .out_addr(out_addr),
    .out_wr(out_wr), .sad_en(sad_en), .adbus_en(adbus_en), .fetch_wide(fetch_wide)
  );

  assign cpu_rdata = (reg_hit && !cpu_wr) ? reg_word : '0;
  assign cpu_ack   = reg_hit || (!gnt_dma && cpu_ext && tgt_ack);
  assign dma_ack   = gnt_dma && dma_req && tgt_ack;

  // R10
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_ack && cpu_ack && !reg_hit));
  // R9
  held_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_open && $stable(cyc) && $stable(gnt_dma)) |->
      $stable({rom_sel, sdram_sel, pcs_sel}));
  // R2
  reg_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && !dma_req && !cyc_open) |-> !(rom_sel || sdram_sel || pcs_sel));
endmodule

// File: tb/shadow_bus_ctrl_bench.sv
module shadow_bus_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0, boot8 = 1'b0;
  logic        cpu_req = 0, cpu_fetch = 0, cpu_wr = 0, cpu_io = 0;
  logic [19:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_ack, dma_ack;
  logic        dma_req = 0, dma_wr = 0, tgt_ack = 0;
  logic [19:0] dma_addr = '0;
  logic        rom_sel, sdram_sel, pcs_sel, out_wr, sad_en, adbus_en, fetch_wide;
  logic [19:0] out_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [2:0] S_ROM = 3'b100, S_SD = 3'b010, S_PCS = 3'b001, S_NO = 3'b000;

  always #10 clk = ~clk;

  shadow_bus_ctrl u_shadow_bus_ctrl (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    cpu_req = 0; cpu_fetch = 0; cpu_wr = 0; cpu_io = 0;
    dma_req = 0; dma_wr = 0; tgt_ack = 0;
  endtask

  task automatic reg_write(logic [15:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_io = 1; cpu_wr = 1; cpu_addr = 20'h000EA; cpu_wdata = d;
    #2;
    check("R2 reg write ack", {cpu_ack, rom_sel, sdram_sel, pcs_sel}, 4'b1000);
    @(posedge clk); #1 idle();
  endtask

  task automatic reg_read(logic [15:0] exp, string tag);
    @(negedge clk);
    cpu_req = 1; cpu_io = 1; cpu_wr = 0; cpu_addr = 20'h000EA;
    #2;
    check(tag, cpu_rdata, exp);
    @(posedge clk); #1 idle();
  endtask

  // One acknowledged cycle from either master.
  task automatic access(bit dma, bit fetch, bit wr, bit io, logic [19:0] a,
                        logic [2:0] exp_sel, logic [19:0] exp_addr, string tag);
    @(negedge clk);
    if (dma) begin dma_req = 1; dma_wr = wr; dma_addr = a; end
    else begin cpu_req = 1; cpu_fetch = fetch; cpu_wr = wr; cpu_io = io; cpu_addr = a; end
    tgt_ack = 1;
    #2;
    check(tag, {rom_sel, sdram_sel, pcs_sel}, exp_sel);
    check({tag, " addr"}, out_addr, exp_addr);
    check({tag, " ack"}, dma ? {dma_ack, cpu_ack} : {cpu_ack, dma_ack}, 2'b10);
    @(posedge clk); #1 idle();
  endtask

  task automatic t_reset();
    reg_read(16'h0000, "R1 reset word");
    access(0, 1, 0, 0, 20'hF0000, S_ROM, 20'hF0000, "R1 reset fetch");
  endtask

  task automatic t_register();
    reg_write(16'hFFFF);
    reg_read(16'h8007, "R2 unimplemented zero");
    reg_write(16'h0003);
    reg_read(16'h0003, "R2 mode 11 readback");
  endtask

  task automatic t_normal();
    access(0, 1, 0, 0, 20'hF1234, S_ROM, 20'hF1234, "R3 mode11 fetch rom");
    access(0, 0, 0, 0, 20'h01000, S_SD,  20'h01000, "R3 mode11 read sdram");
    reg_write(16'h0000);
    access(0, 0, 0, 0, 20'hF0002, S_ROM, 20'hF0002, "R3 normal data rom");
  endtask

  task automatic t_copy();
    reg_write(16'h0001);
    access(1, 0, 0, 0, 20'hF0020, S_ROM, 20'hF0020, "R4 dma read rom");
    access(1, 0, 1, 0, 20'hF0020, S_SD,  20'hF0020, "R4 dma write sdram");
    access(0, 1, 0, 0, 20'hF0030, S_ROM, 20'hF0030, "R4 cpu fetch rom");
  endtask

  task automatic t_shadow();
    reg_write(16'h0002);
    access(0, 1, 0, 0, 20'hF0010, S_SD,  20'hF0010, "R5 shadow fetch sdram");
    access(0, 0, 0, 0, 20'hF0010, S_ROM, 20'hF0010, "R5 shadow data rom");
  endtask

  task automatic t_periph();
    reg_write(16'h0000);
    @(negedge clk);
    cpu_req = 1; cpu_addr = 20'hC0040; tgt_ack = 1; #2;
    check("R6 slow bus", {pcs_sel, sad_en, adbus_en}, 3'b110);
    @(posedge clk); #1 idle();
    reg_write(16'h8000);
    @(negedge clk);
    cpu_req = 1; cpu_addr = 20'hC0040; tgt_ack = 1; #2;
    check("R6 normal bus", {pcs_sel, sad_en, adbus_en}, 3'b101);
    @(posedge clk); #1 idle();
    access(0, 0, 0, 1, 20'hA1234, S_PCS, 20'h01234, "R7 io cycle");
  endtask

  task automatic t_width();
    reg_write(16'h0000);
    boot8 = 1;
    @(negedge clk); cpu_req = 1; cpu_fetch = 1; cpu_addr = 20'hF0000; tgt_ack = 1; #2;
    check("R8 narrow boot", fetch_wide, 1'b0);
    @(posedge clk); #1 idle();
    reg_write(16'h0004);
    @(negedge clk); cpu_req = 1; cpu_fetch = 1; cpu_addr = 20'hF0000; tgt_ack = 1; #2;
    check("R8 wide bit", fetch_wide, 1'b1);
    @(posedge clk); #1 idle();
    reg_write(16'h0000); boot8 = 0;
    @(negedge clk); cpu_req = 1; cpu_fetch = 1; cpu_addr = 20'hF0000; tgt_ack = 1; #2;
    check("R8 wide boot", fetch_wide, 1'b1);
    @(posedge clk); #1 idle();
  endtask

  task automatic t_boundary();
    reg_write(16'h0001);
    @(negedge clk); dma_req = 1; dma_wr = 1; dma_addr = 20'hF0020; #2;
    check("R9 start in copy", {rom_sel, sdram_sel, pcs_sel}, S_SD);
    @(negedge clk); cpu_req = 1; cpu_io = 1; cpu_wr = 1; cpu_addr = 20'h000EA; cpu_wdata = 16'h0002; #2;
    check("R9 reg write during dma", {cpu_ack, sdram_sel}, 2'b11);
    @(negedge clk); cpu_req = 0; cpu_io = 0; cpu_wr = 0; #2;
    check("R9 held route", {rom_sel, sdram_sel, pcs_sel}, S_SD);
    tgt_ack = 1; #1;
    check("R9 dma ack", dma_ack, 1'b1);
    @(negedge clk); tgt_ack = 0; #2;
    check("R9 next cycle new mode", {rom_sel, sdram_sel, pcs_sel}, S_ROM);
    @(posedge clk); #1 idle();
  endtask

  task automatic t_arbiter();
    reg_write(16'h0000);
    @(negedge clk); cpu_req = 1; cpu_fetch = 1; cpu_addr = 20'hF0000; #2;
    check("R10 cpu owns", out_addr, 20'hF0000);
    @(negedge clk); dma_req = 1; dma_wr = 1; dma_addr = 20'h00500; tgt_ack = 1; #2;
    check("R10 owner kept", {out_addr, cpu_ack, dma_ack}, {20'hF0000, 2'b10});
    @(negedge clk); #2;
    check("R10 dma wins", {out_addr, sdram_sel, out_wr, cpu_ack, dma_ack}, {20'h00500, 4'b1101});
    @(posedge clk); #1 idle();
    #2 check("R10 idle no select", {rom_sel, sdram_sel, pcs_sel}, S_NO);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_register();
    t_normal();
    t_copy();
    t_shadow();
    t_periph();
    t_width();
    t_boundary();
    t_arbiter();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule